// File: doc/BRIEF.md
# Landing-Pad Expectation Tracker

This block holds the one-bit "landing pad expected" state of a forward-edge control-flow integrity scheme and checks incoming instructions against it. It sits beside the fetch and execute stages of a RISC-V core. An indirect jump (JALR, C.JR or C.JALR) that retires with a qualifying source register arms the state. The next instruction that reaches the check port must then be a landing pad: an aligned, uncompressed AUIPC with rd = x0. Its 20-bit label must be zero or equal to bits 31:12 of x7. Otherwise the block asks the trap logic for a software-check exception.

The trap entry and trap return hooks live in a separate block. They overwrite the state through a load strobe, so a trap can clear it and a return can restore it. All event inputs are single-cycle strobes and are never back-pressured. The core must sample the fault and clear outputs in the same cycle as the instruction strobe: a fault blocks retirement of that instruction, and a clear retires it. Control-flow integrity is switched on or off by a level input that gives the enable for the current privilege.

Top module: `lp_guard`

## Requirements
- R1: After reset the expectation state is 0 (none expected), and no fault or clear is signalled.
- R2: When the enable is 1, a retiring indirect jump whose rs1 is not x1, x5 or x7 sets the state to 1 on the next clock edge.
- R3: An indirect jump with rs1 equal to x1, x5 or x7 never sets the state.
- R4: With state 1 and enable 1, an instruction is accepted as a landing pad when all of these hold: word[6:0] = 0010111, word[11:7] = 00000, PC[1:0] = 00, the compressed flag is 0, and the label word[31:12] is zero or equals x7[31:12]. Acceptance raises the clear pulse in the same cycle, and the state reads 0 after the next edge.
- R5: With state 1 and enable 1, a compressed instruction, an instruction at a PC whose bits [1:0] are not 00, or a word that is not the landing-pad encoding raises the fault in the same cycle.
- R6: With state 1 and enable 1, a landing pad whose label is nonzero and differs from x7[31:12] raises the fault and no clear.
- R7: When a fault is raised, the cause output reads 18 and the trap value reads 2. Causes 16 and 17 are never produced, and both outputs read 0 when there is no fault.
- R8: When the enable is 0, no jump arms the state and no instruction raises a fault or a clear; the state keeps its value.
- R9: A hook load sets the state to the supplied value and takes priority over arming in the same cycle. Arming in turn takes priority over a clear.
- R10: With state 0, a landing-pad instruction acts as a no-op: no clear and no fault.
- R11: A fault does not change the state; it stays 1 until a hook load changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_enable | input | 1 | Landing-pad enable for the current privilege |
| jump_valid | input | 1 | Strobe: an indirect jump retires this cycle |
| jump_rs1 | input | 5 | Source register index of that jump |
| insn_valid | input | 1 | Strobe: an instruction is at the check point |
| insn_word | input | 32 | Instruction word |
| insn_pc_low | input | 2 | PC bits [1:0] of that instruction |
| insn_compressed | input | 1 | The instruction is 16-bit |
| x7_label | input | 20 | Bits 31:12 of register x7 |
| hook_load | input | 1 | Strobe from trap entry or return: load the state |
| hook_value | input | 1 | Value to load |
| elp | output | 1 | Current expectation state |
| fault_valid | output | 1 | Software-check fault request, same cycle as insn_valid |
| fault_cause | output | CAUSE_W | Exception cause (18 on fault) |
| fault_tval | output | XLEN | Trap value (2 on fault) |
| lp_clear | output | 1 | Landing pad accepted; the state clears at the next edge |

## Verification
The bench targets the three exempt source registers. A design that tested the wrong indices would arm on a return, or let an ordinary jump go unchecked. It checks the label wildcard and mismatch paths: a design that treated zero as a literal label would fault valid pads, and one that skipped the compare would accept a wrong target. It covers misaligned and compressed landings, which look like valid pads in their other bits, and landing pads seen while the state is 0, which must do nothing. It also covers the priority of a hook load over a same-cycle jump, and the rule that a fault leaves the state armed instead of silently clearing it.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned LABEL_W   = 20;
  localparam int unsigned INSN_W    = 32;
  localparam int unsigned RD_LSB    = 7;
  localparam int unsigned N_EXEMPT  = 3;

  localparam logic [6:0] OPC_AUIPC = 7'b0010111;

  localparam int unsigned SWCHK_CAUSE = 18;
  localparam int unsigned LPAD_TVAL   = 2;

  // return-link registers and the software-guarded jump register
  localparam logic [REG_IDX_W-1:0] EXEMPT_REGS [N_EXEMPT] = '{5'd1, 5'd5, 5'd7};

  typedef enum logic {
    ELP_IDLE  = 1'b0,
    ELP_ARMED = 1'b1
  } elp_e;

  function automatic logic reg_is_exempt(input logic [REG_IDX_W-1:0] r);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < N_EXEMPT; i++) begin
      if (r == EXEMPT_REGS[i]) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/lpg_arm_qual.sv
module lpg_arm_qual
  import lpg_pkg::*;
(
  input  logic                 jump_valid,
  input  logic [REG_IDX_W-1:0] jump_rs1,
  input  logic                 lp_enable,
  output logic                 arm
);
  logic [N_EXEMPT-1:0] hit;

  generate
    for (genvar g = 0; g < N_EXEMPT; g++) begin : g_exempt
      assign hit[g] = (jump_rs1 == EXEMPT_REGS[g]);
    end
  endgenerate

  always_comb begin
    arm = jump_valid & lp_enable & ~(|hit);
  end
endmodule

// File: rtl/lpg_insn_check.sv
module lpg_insn_check
  import lpg_pkg::*;
(
  input  logic               elp_armed,
  input  logic               lp_enable,
  input  logic               insn_valid,
  input  logic [INSN_W-1:0]  insn_word,
  input  logic [1:0]         insn_pc_low,
  input  logic               insn_compressed,
  input  logic [LABEL_W-1:0] x7_label,
  output logic               fault,
  output logic               clear
);
  localparam int unsigned LBL_LSB = INSN_W - LABEL_W;

  logic               enc_ok;
  logic               shape_bad;
  logic               label_ok;
  logic               active;
  logic [LABEL_W-1:0] label;

  always_comb begin
    label     = insn_word[INSN_W-1:LBL_LSB];
    enc_ok    = (insn_word[6:0] == OPC_AUIPC) &&
                (insn_word[LBL_LSB-1:RD_LSB] == '0);
    shape_bad = insn_compressed | (insn_pc_low != 2'b00) | ~enc_ok;
    label_ok  = (label == '0) || (label == x7_label);
    active    = insn_valid & lp_enable & elp_armed;
    fault     = active & (shape_bad | ~label_ok);
    clear     = active & ~shape_bad & label_ok;
  end
endmodule

// File: rtl/lpg_state.sv
module lpg_state
  import lpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hook_load,
  input  logic hook_value,
  input  logic arm,
  input  logic clear,
  output elp_e state
);
  elp_e nxt;

  always_comb begin
    if (hook_load)  nxt = elp_e'(hook_value);
    else if (arm)   nxt = ELP_ARMED;
    else if (clear) nxt = ELP_IDLE;
    else            nxt = state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ELP_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/lp_guard.sv
module lp_guard
  import lpg_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lp_enable,
  input  logic                 jump_valid,
  input  logic [REG_IDX_W-1:0] jump_rs1,
  input  logic                 insn_valid,
  input  logic [INSN_W-1:0]    insn_word,
  input  logic [1:0]           insn_pc_low,
  input  logic                 insn_compressed,
  input  logic [LABEL_W-1:0]   x7_label,
  input  logic                 hook_load,
  input  logic                 hook_value,
  output logic                 elp,
  output logic                 fault_valid,
  output logic [CAUSE_W-1:0]   fault_cause,
  output logic [XLEN-1:0]      fault_tval,
  output logic                 lp_clear
);
  logic arm;
  logic chk_fault;
  logic chk_clear;
  elp_e state;

  lpg_arm_qual u_arm (
    .jump_valid (jump_valid),
    .jump_rs1   (jump_rs1),
    .lp_enable  (lp_enable),
    .arm        (arm)
  );

  lpg_insn_check u_check (
    .elp_armed       (state == ELP_ARMED),
    .lp_enable       (lp_enable),
    .insn_valid      (insn_valid),
    .insn_word       (insn_word),
    .insn_pc_low     (insn_pc_low),
    .insn_compressed (insn_compressed),
    .x7_label        (x7_label),
    .fault           (chk_fault),
    .clear           (chk_clear)
  );

  lpg_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .hook_load  (hook_load),
    .hook_value (hook_value),
    .arm        (arm),
    .clear      (chk_clear),
    .state      (state)
  );

  always_comb begin
    elp         = (state == ELP_ARMED);
    fault_valid = chk_fault;
    lp_clear    = chk_clear;
    fault_cause = chk_fault ? CAUSE_W'(SWCHK_CAUSE) : '0;
    fault_tval  = chk_fault ? XLEN'(LPAD_TVAL) : '0;
  end
endmodule

// File: rtl/lp_guard_chk.sv
module lp_guard_chk
  import lpg_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lp_enable,
  input logic                 jump_valid,
  input logic [REG_IDX_W-1:0] jump_rs1,
  input logic                 insn_valid,
  input logic                 hook_load,
  input logic                 elp,
  input logic                 fault_valid,
  input logic [CAUSE_W-1:0]   fault_cause,
  input logic [XLEN-1:0]      fault_tval,
  input logic                 lp_clear
);
  AST_ARM_ON_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_valid && lp_enable && !reg_is_exempt(jump_rs1) && !hook_load) |=> elp); // R2
  AST_EXEMPT_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!elp && jump_valid && reg_is_exempt(jump_rs1) && !hook_load) |=> !elp); // R3
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_clear && !jump_valid && !hook_load) |=> !elp); // R4
  AST_FAULT_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (fault_cause == CAUSE_W'(18) && fault_tval == XLEN'(2))); // R7
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cause != CAUSE_W'(16)) && (fault_cause != CAUSE_W'(17))); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_enable |-> (!fault_valid && !lp_clear)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !elp |-> (!fault_valid && !lp_clear)); // R10
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !hook_load) |=> elp); // R11
  AST_NEEDS_INSN: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid || lp_clear) |-> (insn_valid && !(fault_valid && lp_clear))); // R5
endmodule

bind lp_guard lp_guard_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lp_enable   (lp_enable),
  .jump_valid  (jump_valid),
  .jump_rs1    (jump_rs1),
  .insn_valid  (insn_valid),
  .hook_load   (hook_load),
  .elp         (elp),
  .fault_valid (fault_valid),
  .fault_cause (fault_cause),
  .fault_tval  (fault_tval),
  .lp_clear    (lp_clear)
);

// File: tb/lp_guard_bench.sv
module lp_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lp_enable = 1'b0;
  logic        jump_valid = 1'b0;
  logic [4:0]  jump_rs1 = '0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic [1:0]  insn_pc_low = '0;
  logic        insn_compressed = 1'b0;
  logic [19:0] x7_label = '0;
  logic        hook_load = 1'b0;
  logic        hook_value = 1'b0;
  logic        elp;
  logic        fault_valid;
  logic [4:0]  fault_cause;
  logic [31:0] fault_tval;
  logic        lp_clear;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_guard u_lp_guard (
    .clk(clk), .rst_n(rst_n), .lp_enable(lp_enable),
    .jump_valid(jump_valid), .jump_rs1(jump_rs1),
    .insn_valid(insn_valid), .insn_word(insn_word),
    .insn_pc_low(insn_pc_low), .insn_compressed(insn_compressed),
    .x7_label(x7_label), .hook_load(hook_load), .hook_value(hook_value),
    .elp(elp), .fault_valid(fault_valid), .fault_cause(fault_cause),
    .fault_tval(fault_tval), .lp_clear(lp_clear)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lpad(input logic [19:0] lbl);
    return {lbl, 5'b00000, 7'b0010111};
  endfunction

  // one jump strobe; state is sampled after the edge
  task automatic do_jump(input logic [4:0] rs1);
    @(negedge clk);
    jump_valid = 1'b1; jump_rs1 = rs1;
    @(negedge clk);
    jump_valid = 1'b0;
  endtask

  task automatic do_hook(input logic v);
    @(negedge clk);
    hook_load = 1'b1; hook_value = v;
    @(negedge clk);
    hook_load = 1'b0;
  endtask

  // present one instruction, capture same-cycle outputs
  task automatic do_insn(input logic [31:0] w, input logic [1:0] pcl, input logic c,
                         output logic f, output logic cl,
                         output logic [4:0] cause, output logic [31:0] tval);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = w; insn_pc_low = pcl; insn_compressed = c;
    #1;
    f = fault_valid; cl = lp_clear; cause = fault_cause; tval = fault_tval;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "elp in reset", elp, 0);
    chk("R1", "fault in reset", fault_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "elp after reset", elp, 0);
    chk("R1", "clear after reset", lp_clear, 0);
  endtask

  task automatic t_arm_and_land;
    logic f, cl; logic [4:0] ca; logic [31:0] tv;
    lp_enable = 1'b1; x7_label = 20'h12345;
    do_jump(5'd10);
    chk("R2", "armed by x10", elp, 1);
    do_insn(lpad(20'h12345), 2'b00, 1'b0, f, cl, ca, tv);
    chk("R4", "match clear", cl, 1);
    chk("R4", "match no fault", f, 0);
    chk("R4", "elp after land", elp, 0);
    do_jump(5'd0);
    chk("R2", "armed by x0", elp, 1);
    do_insn(lpad(20'h0), 2'b00, 1'b0, f, cl, ca, tv);
    chk("R4", "wildcard clear", cl, 1);
    chk("R4", "elp after wildcard", elp, 0);
  endtask

  task automatic t_exempt;
    lp_enable = 1'b1;
    do_jump(5'd1);
    chk("R3", "x1 no arm", elp, 0);
    do_jump(5'd5);
    chk("R3", "x5 no arm", elp, 0);
    do_jump(5'd7);
    chk("R3", "x7 no arm", elp, 0);
    do_jump(5'd6);
    chk("R2", "x6 arms", elp, 1);
    do_hook(1'b0);
  endtask

  task automatic t_shape_faults;
    logic f, cl; logic [4:0] ca; logic [31:0] tv;
    lp_enable = 1'b1; x7_label = 20'h00abc;
    do_jump(5'd11);
    do_insn(lpad(20'h00abc), 2'b00, 1'b1, f, cl, ca, tv);
    chk("R5", "compressed fault", f, 1);
    chk("R7", "cause", ca, 18);
    chk("R7", "tval", tv, 2);
    chk("R11", "elp held after fault", elp, 1);
    do_insn(lpad(20'h00abc), 2'b10, 1'b0, f, cl, ca, tv);
    chk("R5", "misaligned fault", f, 1);
    chk("R5", "misaligned no clear", cl, 0);
    do_insn(32'h00000033, 2'b00, 1'b0, f, cl, ca, tv);
    chk("R5", "non-lpad fault", f, 1);
    do_insn({20'h00abc, 5'd3, 7'b0010111}, 2'b00, 1'b0, f, cl, ca, tv);
    chk("R5", "auipc rd!=0 fault", f, 1);
    do_hook(1'b0);
    chk("R11", "hook clears", elp, 0);
  endtask

  task automatic t_label;
    logic f, cl; logic [4:0] ca; logic [31:0] tv;
    lp_enable = 1'b1; x7_label = 20'h00111;
    do_jump(5'd12);
    do_insn(lpad(20'h00222), 2'b00, 1'b0, f, cl, ca, tv);
    chk("R6", "mismatch fault", f, 1);
    chk("R6", "mismatch no clear", cl, 0);
    chk("R11", "elp held", elp, 1);
    do_hook(1'b0);
  endtask

  task automatic t_disabled;
    logic f, cl; logic [4:0] ca; logic [31:0] tv;
    lp_enable = 1'b0;
    do_jump(5'd10);
    chk("R8", "no arm when disabled", elp, 0);
    do_hook(1'b1);
    do_insn(32'h00000033, 2'b00, 1'b0, f, cl, ca, tv);
    chk("R8", "no fault when disabled", f, 0);
    chk("R8", "no clear when disabled", cl, 0);
    chk("R8", "state kept", elp, 1);
    chk("R7", "cause zero when idle", ca, 0);
    do_hook(1'b0);
    lp_enable = 1'b1;
  endtask

  task automatic t_idle_lpad;
    logic f, cl; logic [4:0] ca; logic [31:0] tv;
    lp_enable = 1'b1;
    do_insn(lpad(20'h55555), 2'b00, 1'b0, f, cl, ca, tv);
    chk("R10", "idle lpad no clear", cl, 0);
    chk("R10", "idle lpad no fault", f, 0);
    do_insn(32'h00000013, 2'b10, 1'b1, f, cl, ca, tv);
    chk("R10", "idle other no fault", f, 0);
    chk("R10", "elp stays 0", elp, 0);
  endtask

  task automatic t_priority;
    lp_enable = 1'b1;
    @(negedge clk);
    hook_load = 1'b1; hook_value = 1'b0; jump_valid = 1'b1; jump_rs1 = 5'd10;
    @(negedge clk);
    hook_load = 1'b0; jump_valid = 1'b0;
    chk("R9", "hook beats jump", elp, 0);
    do_hook(1'b1);
    chk("R9", "hook restores 1", elp, 1);
    // jump and accepted pad in one cycle: jump wins
    @(negedge clk);
    x7_label = 20'h0; insn_valid = 1'b1; insn_word = lpad(20'h0);
    insn_pc_low = 2'b00; insn_compressed = 1'b0;
    jump_valid = 1'b1; jump_rs1 = 5'd9;
    @(negedge clk);
    insn_valid = 1'b0; jump_valid = 1'b0;
    chk("R9", "jump beats clear", elp, 1);
    do_hook(1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_arm_and_land();
    t_exempt();
    t_shape_faults();
    t_label();
    t_disabled();
    t_idle_lpad();
    t_priority();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule